// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame should be kept, looking only at the six destination-address bytes that open the frame. The bytes arrive one per accepted cycle on a byte stream. While they stream in, the block keeps a running CRC-32 for the multicast hash and compares the bytes against a programmed station address. It also tracks whether the address so far is all ones and whether the first byte marks a group address.

One cycle after the sixth byte is taken, the block raises a single-cycle `done` strobe. At the same time `accept` shows the verdict, and `accept` holds that value until the next verdict. The verdict follows a fixed priority. A promiscuous enable accepts everything. If that enable is clear, an all-ones (broadcast) address depends only on the broadcast enable. Any other address with the group bit set needs the multicast enable and a hit in a 64-bit hash table. An individual address needs an exact six-byte match with the station address.

The controller has three states:
- `S_IDLE` waits for the first byte. It moves to `S_COLLECT` when a byte is taken.
- `S_COLLECT` counts bytes. It moves to `S_DONE` when the last byte is taken.
- `S_DONE` presents the strobe. It always returns to `S_IDLE` on the next cycle.

Top module: `dafilt_top`

## Requirements
- R1: With `cfg_promisc` high in the cycle the sixth byte is taken, the verdict is accept for any address.
- R2: With promiscuous mode off, an all-ones address (every byte 0xFF) is accepted if and only if `cfg_bcast` is high.
- R3: An all-ones address never takes the multicast path. With `cfg_bcast` low it is dropped even when `cfg_mcast` is high and every hash-table bit is set.
- R4: A non-broadcast address whose first byte has bit 0 set is accepted only when `cfg_mcast` is high and its hash-table bit is set.
- R5: The hash index is bits 31..26 of a CRC-32 taken over the six bytes in arrival order. The CRC starts from all ones, uses polynomial 0x04C11DB7, shifts left, feeds each byte least significant bit first, and has no final inversion.
- R6: The hash bit for index k is `hash_table[k]`, which is bit k mod 8 of table byte k/8, with byte j held in `hash_table[8j+7:8j]`.
- R7: An address whose first byte has bit 0 clear is accepted only if every byte i equals `station_addr[8i+7:8i]`, with byte 0 arriving first. A mismatch in any single byte drops the frame.
- R8: `done` is high for exactly the one cycle after the sixth byte is taken. `accept` changes only in that cycle and holds its value otherwise.
- R9: During and right after reset, `done` and `accept` are low.
- R10: Cycles with `byte_valid` low are not counted. Gaps between address bytes do not change the verdict or the timing relative to the sixth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_valid | input | 1 | A destination byte is present this cycle |
| byte_data | input | 8 | Destination byte, first byte of the address first |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bcast | input | 1 | Accept the all-ones address |
| cfg_mcast | input | 1 | Allow hashed group addresses |
| station_addr | input | 48 | Own address, byte i at bits 8i+7:8i |
| hash_table | input | 64 | Multicast hash bits, indexed by hash value |
| done | output | 1 | Verdict strobe, one cycle |
| accept | output | 1 | Verdict, held until the next strobe |

## Verification
The checker assumes three things about the inputs:
- No address byte is offered in the cycle `done` is high. The block ignores such a byte.
- The three enables are settled in the cycle that carries the sixth byte, because that is where they are sampled.
- `station_addr` and `hash_table` stay constant while an address is streaming.

The bench respects all three. It drives every input on the falling edge, leaves one idle cycle after each strobe, and changes the configuration only between addresses. In some addresses it inserts idle cycles between bytes, to exercise the gap rule.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_COLLECT = 2'd1,
        S_DONE    = 2'd2
    } dafilt_state_t;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
endpackage

// File: rtl/dafilt_crc.sv
module dafilt_crc #(
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic [7:0]           din,
    output logic [HASH_BITS-1:0] hidx_nxt
);
    import dafilt_pkg::*;

    logic [31:0] crc_q;
    logic [31:0] crc_nxt;

    // Bit-serial update, LSB of the byte first, register shifting left
    always_comb begin
        crc_nxt = crc_q;
        for (int b = 0; b < 8; b++) begin
            if (crc_nxt[31] ^ din[b]) crc_nxt = (crc_nxt << 1) ^ CRC_POLY;
            else                      crc_nxt = crc_nxt << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc_q <= CRC_INIT;
        else if (clr) crc_q <= CRC_INIT;
        else if (en)  crc_q <= crc_nxt;
    end

    assign hidx_nxt = crc_nxt[31 -: HASH_BITS];
endmodule

// File: rtl/dafilt_match.sv
module dafilt_match #(
    parameter int ADDR_BYTES = 6,
    localparam int CW = $clog2(ADDR_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    first,
    input  logic [CW-1:0]           idx,
    input  logic [7:0]              din,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    output logic                    bc_nxt,
    output logic                    uc_nxt,
    output logic                    grp_nxt
);
    logic       bc_q, uc_q, grp_q;
    logic [7:0] st_byte [ADDR_BYTES];

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_station
        assign st_byte[g] = station_addr[8*g +: 8];
    end

    always_comb begin
        bc_nxt  = (first ? 1'b1 : bc_q) && (din == 8'hFF);
        uc_nxt  = (first ? 1'b1 : uc_q) && (din == st_byte[idx]);
        grp_nxt = first ? din[0] : grp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc_q  <= 1'b0;
            uc_q  <= 1'b0;
            grp_q <= 1'b0;
        end else if (en) begin
            bc_q  <= bc_nxt;
            uc_q  <= uc_nxt;
            grp_q <= grp_nxt;
        end
    end
endmodule

// File: rtl/dafilt_top.sv
module dafilt_top #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    localparam int CW      = $clog2(ADDR_BYTES),
    localparam int TBL_W   = 1 << HASH_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_valid,
    input  logic [7:0]              byte_data,
    input  logic                    cfg_promisc,
    input  logic                    cfg_bcast,
    input  logic                    cfg_mcast,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic [TBL_W-1:0]        hash_table,
    output logic                    done,
    output logic                    accept
);
    import dafilt_pkg::*;

    localparam logic [CW-1:0] LAST_IDX = CW'(ADDR_BYTES - 1);

    dafilt_state_t        state_q, state_d;
    logic [CW-1:0]        idx_q;
    logic                 take, first, last;
    logic                 bc_nxt, uc_nxt, grp_nxt, verdict;
    logic [HASH_BITS-1:0] hidx_nxt;
    logic                 done_q, accept_q;

    assign take  = byte_valid && (state_q != S_DONE);
    assign first = take && (idx_q == '0);
    assign last  = take && (idx_q == LAST_IDX);

    dafilt_crc #(.HASH_BITS(HASH_BITS)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q == S_DONE),
        .en       (take),
        .din      (byte_data),
        .hidx_nxt (hidx_nxt)
    );

    dafilt_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (take),
        .first        (first),
        .idx          (idx_q),
        .din          (byte_data),
        .station_addr (station_addr),
        .bc_nxt       (bc_nxt),
        .uc_nxt       (uc_nxt),
        .grp_nxt      (grp_nxt)
    );

    // Priority: promiscuous, broadcast, group hash, exact unicast
    always_comb begin
        if (cfg_promisc)  verdict = 1'b1;
        else if (bc_nxt)  verdict = cfg_bcast;
        else if (grp_nxt) verdict = cfg_mcast && hash_table[hidx_nxt];
        else              verdict = uc_nxt;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (take) state_d = last ? S_DONE : S_COLLECT;
            S_COLLECT: if (last) state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register and byte counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_DONE) idx_q <= '0;
            else if (take)         idx_q <= last ? '0 : idx_q + 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            accept_q <= 1'b0;
        end else begin
            done_q <= last;
            if (last) accept_q <= verdict;
        end
    end

    assign done   = done_q;
    assign accept = accept_q;
endmodule

// File: rtl/dafilt_chk.sv
module dafilt_chk #(
    parameter int ADDR_BYTES = 6,
    localparam int CW = $clog2(ADDR_BYTES)
) (
    input logic clk,
    input logic rst_n,
    input logic byte_valid,
    input logic cfg_promisc,
    input logic done,
    input logic accept
);
    logic [CW-1:0] seen_q;
    logic          sixth_q;
    logic          take;

    assign take = byte_valid && !done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= '0;
            sixth_q <= 1'b0;
        end else begin
            sixth_q <= take && (seen_q == CW'(ADDR_BYTES - 1));
            if (take) seen_q <= (seen_q == CW'(ADDR_BYTES - 1)) ? '0 : seen_q + 1'b1;
        end
    end

    AST_DONE_AFTER_SIXTH: assert property (@(posedge clk) disable iff (!rst_n) done == sixth_q); // R8 R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_ACCEPT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(accept) |-> done); // R8
    AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (done && $past(cfg_promisc)) |-> accept); // R1

    always @(posedge clk) begin
        if (!rst_n) AST_RESET_QUIET: assert (!done && !accept); // R9
    end
endmodule

bind dafilt_top dafilt_chk #(.ADDR_BYTES(ADDR_BYTES)) u_dafilt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_valid  (byte_valid),
    .cfg_promisc (cfg_promisc),
    .done        (done),
    .accept      (accept)
);

// File: tb/tb_dafilt_top.sv
module tb_dafilt_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        cfg_promisc = 1'b0, cfg_bcast = 1'b0, cfg_mcast = 1'b0;
    logic [47:0] station_addr = 48'h0;
    logic [63:0] hash_table = 64'h0;
    logic        done, accept;

    int errors = 0;
    int checks = 0;

    localparam logic [47:0] STATION = 48'h66_55_44_33_22_12; // byte0 = 0x12
    localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;

    dafilt_top dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .cfg_promisc(cfg_promisc), .cfg_bcast(cfg_bcast), .cfg_mcast(cfg_mcast),
        .station_addr(station_addr), .hash_table(hash_table),
        .done(done), .accept(accept)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [5:0] hash_of(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[31] ^ a[8*i + b];
                c = c << 1;
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic model(input logic [47:0] a);
        if (cfg_promisc)       return 1'b1;
        if (a == BCAST)        return cfg_bcast;
        if (a[0])              return cfg_mcast && hash_table[hash_of(a)];
        return a == station_addr;
    endfunction

    task automatic check(input logic cond, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Stream one address; called and returns on a falling edge
    task automatic run_frame(input logic [47:0] a, input bit gaps, input logic exp,
                             input string tag);
        for (int i = 0; i < 6; i++) begin
            if (gaps) begin
                byte_valid = 1'b0;
                byte_data  = 8'hA5;
                @(negedge clk);
                check(done == 1'b0, "R10", "done during gap", done, 0);
            end
            byte_valid = 1'b1;
            byte_data  = a[8*i +: 8];
            @(negedge clk);
            if (i < 5) check(done == 1'b0, "R8", "early done", done, 0);
        end
        byte_valid = 1'b0;
        check(done == 1'b1, "R8", "done after sixth byte", done, 1);
        check(accept == exp, tag, "verdict", accept, exp);
        check(model(a) == exp, tag, "bench model vs scenario", model(a), exp);
        @(negedge clk);
        check(done == 1'b0, "R8", "done single cycle", done, 0);
        check(accept == exp, "R8", "verdict held", accept, exp);
    endtask

    task automatic t_reset;
        check(done == 1'b0 && accept == 1'b0, "R9", "reset outputs", {done, accept}, 0);
    endtask

    task automatic t_promisc;
        cfg_promisc = 1; cfg_bcast = 0; cfg_mcast = 0; hash_table = '0;
        run_frame(48'h0B_0A_09_08_07_06, 0, 1, "R1");
        run_frame(48'h00_00_00_00_00_01, 0, 1, "R1");
        cfg_promisc = 0;
    endtask

    task automatic t_bcast;
        cfg_bcast = 1; cfg_mcast = 0;
        run_frame(BCAST, 0, 1, "R2");
        cfg_bcast = 0;
        run_frame(BCAST, 0, 0, "R2");
        cfg_mcast = 1; hash_table = '1;
        run_frame(BCAST, 0, 0, "R3");
        cfg_mcast = 0; hash_table = '0;
    endtask

    task automatic t_mcast;
        logic [47:0] a;
        logic [5:0]  k;
        for (int n = 0; n < 4; n++) begin
            a = {8'h10 + 8'(n), 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01} ^ {40'h0, 8'(n * 2)};
            k = hash_of(a);
            cfg_mcast = 1;
            hash_table = 64'h1 << k;
            run_frame(a, 0, 1, "R5");
            hash_table = 64'h1 << (k ^ 6'd1);
            run_frame(a, 0, 0, "R6");
            hash_table = ~(64'h1 << k);
            run_frame(a, 0, 0, "R6");
            cfg_mcast = 0; hash_table = '1;
            run_frame(a, 0, 0, "R4");
        end
        cfg_mcast = 1; hash_table = '1;
        run_frame(48'h23_45_67_89_AB_CD, 1, 1, "R4");
        cfg_mcast = 0; hash_table = '0;
    endtask

    task automatic t_unicast;
        station_addr = STATION;
        run_frame(STATION, 0, 1, "R7");
        run_frame(STATION ^ 48'h01_00_00_00_00_00, 0, 0, "R7");
        run_frame(STATION ^ 48'h00_00_00_80_00_00, 0, 0, "R7");
        run_frame(STATION ^ 48'h00_00_00_00_00_02, 0, 0, "R7");
        cfg_mcast = 1; hash_table = '1; cfg_bcast = 1;
        run_frame(STATION, 0, 1, "R7");
        cfg_mcast = 0; hash_table = '0; cfg_bcast = 0;
    endtask

    task automatic t_gaps;
        station_addr = STATION;
        run_frame(STATION, 1, 1, "R10");
        run_frame(STATION ^ 48'h10_00_00_00_00_00, 1, 0, "R10");
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=completed");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_promisc();
        t_bcast();
        t_mcast();
        t_unicast();
        t_gaps();
        finish_run();
    end
endmodule